// File: doc/BRIEF.md
# Mode-Dependent Four-Pin Bidirectional Port

This block is a small memory-mapped I/O port with four bidirectional pins. A direction register decides which pins drive. A data register holds the levels that driving pins put out. Both registers sit on an 8-bit register bus that has one register-select bit, a write strobe and a read strobe. Read data is combinational and valid in the same cycle as the read strobe. The operating mode is a 3-bit input and is expected to stay fixed outside reset.

In the locked modes (values 1 to 4), all four pins are forced to output and the direction register ignores writes. In every other mode value, software sets the direction bits, but it cannot read them back: a read of the direction register always returns all ones. A read of the data register returns the latched data bit for pins that drive and the synchronized pin level for pins that do not. The four upper bits of that read are reserved and always read as one.

An asynchronous active-high hardware-standby input reinitializes the port in the same way as reset. A software-standby level input freezes both registers, so pins that drive keep their last levels.

Top module: `gpio4_port`

## Requirements
- R1: Pin n drives (pin_oe[n]=1) exactly when its effective direction bit n is 1. pin_out carries the four data-register bits, with bit n on pin n.
- R2: When mode is 1, 2, 3 or 4, pin_oe is 4'b1111 and writes to the direction register (bus_sel=0) have no effect, including after a later write in the same mode.
- R3: A read with bus_sel=0 returns 8'hFF in every mode, whatever was written.
- R4: After reset, the data bits are 0. The direction bits are 0 in modes 0, 5, 6 and 7, so pin_oe is 4'b0000 there. A data-register read (bus_sel=1) returns 8'hF0 when the input pins are low.
- R5: A read with bus_sel=1 returns ones in bits 7:4 whatever value was written to them.
- R6: In a data-register read, bit n (n<4) is data bit n when pin n drives. Otherwise it is the level of pin n, sampled through two flops, so a pin change shows up in reads two rising edges later.
- R7: While sw_standby is 1, bus writes change neither register and pin_oe and pin_out hold their values.
- R8: hw_standby=1 reinitializes both registers at once, without waiting for a clock edge, to the same values as reset.
- R9: Bits 7:4 of a direction-register write have no effect on the pins.
- R10: bus_rdata is 8'h00 whenever bus_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Asynchronous active-high reinitialize |
| sw_standby | input | 1 | Freezes both registers while high |
| mode | input | 3 | Operating mode; 1 to 4 lock the direction |
| bus_sel | input | 1 | Register select: 0 direction, 1 data |
| bus_wr | input | 1 | Write strobe, acts at the rising edge |
| bus_rd | input | 1 | Read strobe, data valid in the same cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 4 | Levels present on the pins |
| pin_oe | output | 4 | Per-pin output enable |
| pin_out | output | 4 | Per-pin output level |

## Verification
A write takes effect at the rising edge where bus_wr is sampled, so pin_oe and pin_out are due just after that edge. Read data follows bus_rd and bus_sel in the same cycle. A pin level reaches a data-register read after the second rising edge that follows the change, and hw_standby acts at once, without a clock. The bench keeps a behavioural model that advances on the same edges, including the two-sample pin delay and the asynchronous clear. It compares every output at the falling edge, when all of these results have settled, and it makes one mid-cycle check right after hw_standby rises.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
    localparam int PORT_W = 4;
    localparam int BUS_W  = 8;
    localparam int MODE_W = 3;
    localparam int LOCK_LO = 1;
    localparam int LOCK_HI = 4;

    typedef enum logic {
        SEL_DIR = 1'b0,
        SEL_DAT = 1'b1
    } reg_sel_e;

    function automatic logic mode_locked(input logic [MODE_W-1:0] m);
        return (int'(m) >= LOCK_LO) && (int'(m) <= LOCK_HI);
    endfunction
endpackage

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         arst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) sync_q <= '0;
        else      sync_q <= sync_d;
    end

    assign sync_out = sync_q.s2;
endmodule

// File: rtl/gpio4_regs.sv
module gpio4_regs
    import gpio4_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          sw_standby,
    input  logic          locked,
    input  logic          wr,
    input  logic          sel,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] dir_q,
    output logic [PW-1:0] dat_q
);
    typedef struct packed {
        logic [PW-1:0] dir;
        logic [PW-1:0] dat;
    } regs_t;

    localparam regs_t RST_VAL = '{dir: '0, dat: '0};

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr && !sw_standby) begin
            if (reg_sel_e'(sel) == SEL_DIR && !locked) regs_d.dir = wdata;
            if (reg_sel_e'(sel) == SEL_DAT)            regs_d.dat = wdata;
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) regs_q <= RST_VAL;
        else      regs_q <= regs_d;
    end

    assign dir_q = regs_q.dir;
    assign dat_q = regs_q.dat;

    // R7
    sw_hold_chk: assert property (@(posedge clk) disable iff (arst)
        sw_standby |=> ($stable(regs_q.dir) && $stable(regs_q.dat)));

    // R2
    locked_wr_chk: assert property (@(posedge clk) disable iff (arst)
        (locked && wr && reg_sel_e'(sel) == SEL_DIR) |=> $stable(regs_q.dir));
endmodule

// File: rtl/gpio4_readmux.sv
module gpio4_readmux
    import gpio4_pkg::*;
#(
    parameter int PW = 4,
    parameter int BW = 8
) (
    input  logic          rd,
    input  logic          sel,
    input  logic [PW-1:0] dir_eff,
    input  logic [PW-1:0] dat,
    input  logic [PW-1:0] pin_sync,
    output logic [BW-1:0] rdata
);
    localparam int RSV_W = BW - PW;

    logic [PW-1:0] mix;

    for (genvar i = 0; i < PW; i++) begin : g_bit
        assign mix[i] = dir_eff[i] ? dat[i] : pin_sync[i];
    end

    always_comb begin
        if (!rd)                           rdata = '0;
        else if (reg_sel_e'(sel) == SEL_DAT) rdata = {{RSV_W{1'b1}}, mix};
        else                               rdata = '1;
    end
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
    import gpio4_pkg::*;
#(
    parameter int PIN_W = gpio4_pkg::PORT_W,
    parameter int DBW   = gpio4_pkg::BUS_W,
    parameter int MW    = gpio4_pkg::MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_standby,
    input  logic             sw_standby,
    input  logic [MW-1:0]    mode,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DBW-1:0]   bus_wdata,
    output logic [DBW-1:0]   bus_rdata,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_oe,
    output logic [PIN_W-1:0] pin_out
);
    localparam int RSV_W = DBW - PIN_W;

    logic             arst;
    logic             locked;
    logic [PIN_W-1:0] dir_q, dat_q, dir_eff, pin_sync;
    logic             unused_hi;

    assign arst      = hw_standby | ~rst_n;
    assign locked    = mode_locked(3'(mode));
    assign unused_hi = &{1'b0, bus_wdata[DBW-1:PIN_W]};

    gpio4_regs #(.PW(PIN_W)) i_regs (
        .clk        (clk),
        .arst       (arst),
        .sw_standby (sw_standby),
        .locked     (locked),
        .wr         (bus_wr),
        .sel        (bus_sel),
        .wdata      (bus_wdata[PIN_W-1:0]),
        .dir_q      (dir_q),
        .dat_q      (dat_q)
    );

    gpio4_sync #(.W(PIN_W)) i_sync (
        .clk      (clk),
        .arst     (arst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    assign dir_eff = locked ? {PIN_W{1'b1}} : dir_q;
    assign pin_oe  = dir_eff;
    assign pin_out = dat_q;

    gpio4_readmux #(.PW(PIN_W), .BW(DBW)) i_rmux (
        .rd       (bus_rd),
        .sel      (bus_sel),
        .dir_eff  (dir_eff),
        .dat      (dat_q),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata)
    );

    // R2
    locked_oe_chk: assert property (@(posedge clk) disable iff (arst)
        locked |-> (pin_oe == {PIN_W{1'b1}}));

    // R3
    dir_read_ones_chk: assert property (@(posedge clk) disable iff (arst)
        (bus_rd && !bus_sel) |-> (bus_rdata == {DBW{1'b1}}));

    // R5
    rsv_read_ones_chk: assert property (@(posedge clk) disable iff (arst)
        (bus_rd && bus_sel) |-> (bus_rdata[DBW-1:PIN_W] == {RSV_W{1'b1}}));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (arst)
        !bus_rd |-> (bus_rdata == '0));

    // R7
    sw_pins_hold_chk: assert property (@(posedge clk) disable iff (arst)
        sw_standby |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

// File: tb/test_gpio4_port.sv
`timescale 1ns/1ps
module test_gpio4_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, hw_sb = 1'b0, sw_sb = 1'b0;
    logic [2:0] mode = 3'd6;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [3:0] ext_val = 4'h0;
    logic [3:0] pad, oe, pout;

    always #4 clk = ~clk;

    // pin model: the block drives a pad when enabled, otherwise the external source does
    assign pad = (oe & pout) | (~oe & ext_val);

    gpio4_port i_gpio4_port (
        .clk(clk), .rst_n(rst_n), .hw_standby(hw_sb), .sw_standby(sw_sb),
        .mode(mode), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata),
        .pin_in(pad), .pin_oe(oe), .pin_out(pout)
    );

    int checks = 0, fails = 0;
    string cur_req = "R4";
    bit started = 0;

    // behavioural reference
    logic m_arst;
    assign m_arst = hw_sb || !rst_n;
    logic [3:0] m_dir, m_dat;
    logic [3:0] m_hist [2];

    always @(posedge clk or posedge m_arst) begin
        if (m_arst) begin
            m_dir = 0; m_dat = 0; m_hist[0] = 0; m_hist[1] = 0;
        end else begin
            m_hist[1] = m_hist[0];
            m_hist[0] = pad;
            if (wr && !sw_sb) begin
                if (sel) m_dat = wdata[3:0];
                else if (!(mode >= 1 && mode <= 4)) m_dir = wdata[3:0];
            end
        end
    end

    function automatic logic [3:0] exp_oe();
        return (mode >= 1 && mode <= 4) ? 4'hF : m_dir;
    endfunction

    function automatic logic [7:0] exp_rd();
        logic [3:0] e;
        if (!rd) return 8'h00;
        if (!sel) return 8'hFF;
        e = exp_oe();
        for (int i = 0; i < 4; i++) e[i] = e[i] ? m_dat[i] : m_hist[1][i];
        return {4'hF, e};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk({cur_req, " pin_oe"},  {4'h0, oe},   {4'h0, exp_oe()});
            chk({cur_req, " pin_out"}, {4'h0, pout}, {4'h0, m_dat});
            chk({cur_req, " rdata"},   rdata,        exp_rd());
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr_reg(input logic s, input logic [7:0] v);
        step(); sel = s; wdata = v; wr = 1;
        step(); wr = 0;
    endtask

    task automatic rd_reg(input logic s);
        step(); sel = s; rd = 1;
        step(); rd = 0;
    endtask

    task automatic do_reset(input logic [2:0] m);
        step(); rst_n = 0; mode = m;
        step(); step(); rst_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R4: reset state in a software mode
        do_reset(3'd6);
        started = 1;
        cur_req = "R4";
        step();
        chk("R4 oe after reset", {4'h0, oe}, 8'h00);
        chk("R4 out after reset", {4'h0, pout}, 8'h00);
        step(); sel = 1; rd = 1; #1;
        chk("R4 data read after reset", rdata, 8'hF0);
        step(); rd = 0;

        // R1: direction and data reach the pins
        cur_req = "R1";
        wr_reg(1'b1, 8'h0A);
        wr_reg(1'b0, 8'h05);
        step();
        chk("R1 oe", {4'h0, oe}, 8'h05);
        chk("R1 out", {4'h0, pout}, 8'h0A);
        wr_reg(1'b0, 8'h0F); wr_reg(1'b1, 8'h06);

        // R6: read-back mixes data and synchronized pins
        cur_req = "R6";
        wr_reg(1'b0, 8'h03);
        wr_reg(1'b1, 8'h01);
        step(); ext_val = 4'hC; sel = 1; rd = 1;
        #1; chk("R6 read before sync", rdata, 8'hF1);
        step();
        chk("R6 read after one edge", rdata, 8'hF1);
        step();
        chk("R6 read after two edges", rdata, 8'hFD);
        ext_val = 4'h4;
        repeat (3) step();
        chk("R6 pin drop seen", rdata, 8'hF5);
        rd = 0;

        // R3: direction read is all ones
        cur_req = "R3";
        step(); sel = 0; rd = 1; #1;
        chk("R3 dir read", rdata, 8'hFF);
        rd = 0;

        // R5: reserved data bits
        cur_req = "R5";
        wr_reg(1'b1, 8'h0E);
        step(); sel = 1; rd = 1; #1;
        chk("R5 upper bits", {rdata[7:4], 4'h0}, 8'hF0);
        rd = 0;

        // R10: idle read data
        cur_req = "R10";
        step(); sel = 1; #1;
        chk("R10 idle rdata", rdata, 8'h00);

        // R9: upper direction bits ignored
        cur_req = "R9";
        wr_reg(1'b0, 8'hF0);
        step();
        chk("R9 oe with upper bits set", {4'h0, oe}, 8'h00);
        wr_reg(1'b0, 8'hA9);
        step();
        chk("R9 oe low nibble only", {4'h0, oe}, 8'h09);

        // R7: software standby freezes registers
        cur_req = "R7";
        step(); sw_sb = 1;
        wr_reg(1'b0, 8'h06);
        wr_reg(1'b1, 8'h01);
        step();
        chk("R7 oe held", {4'h0, oe}, 8'h09);
        chk("R7 out held", {4'h0, pout}, 8'h0E);
        step(); sw_sb = 0;
        wr_reg(1'b1, 8'h03);
        step();
        chk("R7 write after release", {4'h0, pout}, 8'h03);

        // R8: hardware standby acts without a clock
        cur_req = "R8";
        step(); #2; hw_sb = 1; #1;
        chk("R8 async oe clear", {4'h0, oe}, 8'h00);
        chk("R8 async data clear", {4'h0, pout}, 8'h00);
        step(); step(); hw_sb = 0;
        step();
        chk("R8 oe after release", {4'h0, oe}, 8'h00);

        // R2: locked mode
        cur_req = "R2";
        do_reset(3'd2);
        step();
        chk("R2 oe forced", {4'h0, oe}, 8'h0F);
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h05);
        step();
        chk("R2 dir write ignored", {4'h0, oe}, 8'h0F);
        chk("R2 data drives", {4'h0, pout}, 8'h05);
        step(); sel = 0; rd = 1; #1;
        chk("R2 R3 dir read locked", rdata, 8'hFF);
        step(); sel = 1; #1;
        chk("R2 R6 data read locked", rdata, 8'hF5);
        rd = 0;

        // R4: reset in locked mode 4
        cur_req = "R4";
        do_reset(3'd4);
        step();
        chk("R4 locked reset oe", {4'h0, oe}, 8'h0F);
        chk("R4 locked reset out", {4'h0, pout}, 8'h00);
        do_reset(3'd0);
        step();
        chk("R4 mode0 reset oe", {4'h0, oe}, 8'h00);

        repeat (3) step();
        started = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule